// File: doc/BRIEF.md
# Smart-Card Character-Protocol Command Engine

This block runs the command phase of a character-oriented smart-card exchange. After a start pulse it sends a five-byte command header to a byte transmitter, reading the bytes from an external command buffer through an index/data port. It then watches the byte receiver for procedure bytes and, for each one, decides what happens next. It may stream every remaining command byte, send just the next one, collect the response data, wait for another procedure byte, or take in the two status words and stop.

Received response and status bytes are written to an external response buffer through a write strobe, an index and a data byte. A running count of those bytes is kept at the ports. When the exchange ends, the block gives a one-cycle completion pulse together with an error flag and a two-bit cause. The byte-level serial engine, the guard-time handling and the supply control are outside this block.

Top module: `t0_cmd_engine`

## Requirements
- R1: On `start` the five header bytes (command buffer entries 0 to 4) are sent in index order. A byte is transferred on each clock edge where `tx_valid` and `tx_ready` are both high. Receiver events that arrive before the fifth header byte has been transferred are ignored.
- R2: The instruction byte is header entry 1. A procedure byte counts as an acknowledge when it equals the instruction byte after bit 0 of both has been cleared.
- R3: On an acknowledge while command bytes remain (transfer pointer below `cmd_len`), all remaining bytes are sent back to back, holding through `tx_ready` stalls. The block then waits for the next procedure byte.
- R4: On an acknowledge with no command bytes left, the block receives P3+2 bytes into the response buffer, where P3 is header entry 4, and then finishes without error. A receive error or timeout during this phase aborts with that cause.
- R5: A procedure byte equal to the bit-wise complement of the instruction byte, with bit 0 cleared on both sides, sends exactly one command byte when any remain. The block then waits for the next procedure byte.
- R6: On a complement procedure byte with no command bytes left, the block receives one byte into the response buffer and waits for the next procedure byte. A timeout in place of that byte ends the exchange without error; a receive error aborts it.
- R7: The procedure byte 0x60 causes no transfer and no buffer write; the block keeps waiting for a procedure byte.
- R8: A receive error while waiting for a procedure byte aborts with cause 2. A timeout there aborts with cause 1.
- R9: Any other procedure byte whose upper nibble is 6 or 9 is written to the response buffer as the first status byte. The next received byte is written as the second, and the exchange ends without error.
- R10: `tx_last` is high with the fifth header byte, with the final byte of each back-to-back run, and with every single-byte transfer. It is low with all other transmitted bytes.
- R11: A procedure byte that fits none of the classes above aborts with cause 3. Classes are checked in this order: acknowledge, complement, 0x60, status.
- R12: After reset `busy`, `done`, `err`, `tx_valid` and `rsp_count` are 0. `done` pulses for one cycle when an exchange ends. `err` and `err_cause` are valid with that pulse and hold until the next start; the cause is 0 none, 1 timeout, 2 receive error, 3 protocol. `rsp_count` counts the response writes since start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (taken only when idle) |
| cmd_len | input | LEN_W | Total command length in bytes, at least 5 |
| cmd_idx | output | IDX_W | Command buffer read index |
| cmd_data | input | 8 | Command buffer data at `cmd_idx` |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_last | output | 1 | Final byte of the current transmit run |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_valid | input | 1 | Received byte available (one-cycle pulse) |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Receive error event (one-cycle pulse) |
| rx_tmo | input | 1 | Receive timeout event (one-cycle pulse) |
| rsp_we | output | 1 | Response buffer write strobe |
| rsp_idx | output | RSP_W | Response buffer write index |
| rsp_byte | output | 8 | Response buffer write data |
| rsp_count | output | RSP_W | Response bytes written since start |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| err | output | 1 | Exchange ended in error |
| err_cause | output | 2 | Error cause code |

## Verification
The bench aims at the decode corners. It sends acknowledge and complement bytes that differ from the instruction only in bit 0, a null byte placed between single-byte transfers, and a status byte in the 0x6X range as well as 0x9X. A decoder that compared bit 0 would fall into the protocol-error path, and one that mishandled the null byte would send or store a spurious byte. It checks the P3+2 receive length exactly, because an off-by-one finishes early or hangs. It also checks the `tx_last` placement under a stalling transmitter, and that a receive event arriving during the header is dropped rather than taken as a status byte. On the error side, it separates the timeout that ends single-byte receive cleanly from the timeouts that abort elsewhere, and a design that confused them would report the wrong `err`/`err_cause`.

// File: rtl/t0p_pkg.sv
package t0p_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HDR   = 3'd1,
    S_PROC  = 3'd2,
    S_BURST = 3'd3,
    S_ONE   = 3'd4,
    S_RXN   = 3'd5,
    S_RX1   = 3'd6,
    S_SW2   = 3'd7
  } eng_state_t;

  typedef enum logic [1:0] {
    C_NONE  = 2'd0,
    C_TMO   = 2'd1,
    C_RXE   = 2'd2,
    C_PROTO = 2'd3
  } fail_cause_t;

  typedef enum logic [2:0] {
    PB_ACK  = 3'd0,
    PB_CPL  = 3'd1,
    PB_WAIT = 3'd2,
    PB_STAT = 3'd3,
    PB_BAD  = 3'd4
  } pb_kind_t;

  localparam logic [7:0] WAIT_BYTE = 8'h60;
  localparam int unsigned HDR_BYTES = 5;
  localparam int unsigned INS_POS   = 1;
  localparam int unsigned P3_POS    = 4;

endpackage

// File: rtl/t0p_classify.sv
module t0p_classify
  import t0p_pkg::*;
(
  input  logic [7:0] ins,
  input  logic [7:0] pb,
  output pb_kind_t   kind
);

  logic is_ack;
  logic is_cpl;
  logic is_stat;

  always_comb begin
    is_ack  = (pb[7:1] == ins[7:1]);
    is_cpl  = (pb[7:1] == ~ins[7:1]);
    is_stat = (pb[7:4] == 4'h6) || (pb[7:4] == 4'h9);
    if (is_ack)                 kind = PB_ACK;
    else if (is_cpl)            kind = PB_CPL;
    else if (pb == WAIT_BYTE)   kind = PB_WAIT;
    else if (is_stat)           kind = PB_STAT;
    else                        kind = PB_BAD;
  end

endmodule

// File: rtl/t0p_hdr_regs.sv
module t0p_hdr_regs
  import t0p_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [LEN_W-1:0] pos,
  input  logic [7:0]       data,
  output logic [7:0]       ins,
  output logic [7:0]       p3
);

  logic [7:0] ins_q, ins_d;
  logic [7:0] p3_q, p3_d;

  always_comb begin
    ins_d = ins_q;
    p3_d  = p3_q;
    if (cap_en && (pos == LEN_W'(INS_POS))) ins_d = data;
    if (cap_en && (pos == LEN_W'(P3_POS)))  p3_d  = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= 8'h00;
      p3_q  <= 8'h00;
    end else if (cap_en) begin
      ins_q <= ins_d;
      p3_q  <= p3_d;
    end
  end

  assign ins = ins_q;
  assign p3  = p3_q;

endmodule

// File: rtl/t0p_count.sv
module t0p_count #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R12: the count moves by one per write, or returns to zero on clear
  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/t0_cmd_engine.sv
module t0_cmd_engine
  import t0p_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned RSP_W     = 9,
  localparam int unsigned IDX_W    = $clog2(CMD_DEPTH),
  localparam int unsigned LEN_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_len,
  output logic [IDX_W-1:0] cmd_idx,
  input  logic [7:0]       cmd_data,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_last,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_err,
  input  logic             rx_tmo,
  output logic             rsp_we,
  output logic [RSP_W-1:0] rsp_idx,
  output logic [7:0]       rsp_byte,
  output logic [RSP_W-1:0] rsp_count,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_cause
);

  eng_state_t        state_q, state_d;
  logic [LEN_W-1:0]  ptr_q, ptr_d;
  logic [RSP_W-1:0]  xcnt_q, xcnt_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  fail_cause_t       cause_q, cause_d;

  logic [7:0]        ins_b;
  logic [7:0]        p3_b;
  pb_kind_t          kind;
  logic              tx_fire;
  logic              rx_good;
  logic              remain;
  logic              at_hdr_end;
  logic              at_cmd_end;
  logic [RSP_W-1:0]  rxn_final;
  logic              launch;

  assign launch     = (state_q == S_IDLE) && start;
  assign tx_fire    = tx_valid && tx_ready;
  assign rx_good    = rx_valid && !rx_err && !rx_tmo;
  assign remain     = (ptr_q < cmd_len);
  assign at_hdr_end = (ptr_q == LEN_W'(HDR_BYTES - 1));
  assign at_cmd_end = (ptr_q == (cmd_len - LEN_W'(1)));
  assign rxn_final  = RSP_W'(p3_b) + RSP_W'(1);

  t0p_hdr_regs #(.LEN_W(LEN_W)) u_hdr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en ((state_q == S_HDR) && tx_fire),
    .pos    (ptr_q),
    .data   (cmd_data),
    .ins    (ins_b),
    .p3     (p3_b)
  );

  t0p_classify u_cls (
    .ins  (ins_b),
    .pb   (rx_byte),
    .kind (kind)
  );

  t0p_count #(.W(RSP_W)) u_rcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch),
    .inc   (rsp_we),
    .cnt   (rsp_count)
  );

  // transmit side
  assign cmd_idx  = ptr_q[IDX_W-1:0];
  assign tx_byte  = cmd_data;
  assign tx_valid = (state_q == S_HDR) || (state_q == S_BURST) || (state_q == S_ONE);
  assign tx_last  = ((state_q == S_HDR) && at_hdr_end) ||
                    ((state_q == S_BURST) && at_cmd_end) ||
                    (state_q == S_ONE);

  // response side
  always_comb begin
    rsp_we = 1'b0;
    case (state_q)
      S_PROC:               rsp_we = rx_good && (kind == PB_STAT);
      S_RXN, S_RX1, S_SW2:  rsp_we = rx_good;
      default:              rsp_we = 1'b0;
    endcase
  end
  assign rsp_idx  = rsp_count;
  assign rsp_byte = rx_byte;

  // next-state
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    xcnt_d  = xcnt_q;
    done_d  = 1'b0;
    err_d   = err_q;
    cause_d = cause_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_HDR;
          ptr_d   = '0;
          err_d   = 1'b0;
          cause_d = C_NONE;
        end
      end
      S_HDR: begin
        if (tx_fire) begin
          ptr_d = ptr_q + LEN_W'(1);
          if (at_hdr_end) state_d = S_PROC;
        end
      end
      S_PROC: begin
        if (rx_err) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = 1'b1; cause_d = C_RXE;
        end else if (rx_tmo) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = 1'b1; cause_d = C_TMO;
        end else if (rx_valid) begin
          case (kind)
            PB_ACK: begin
              if (remain) state_d = S_BURST;
              else begin
                state_d = S_RXN;
                xcnt_d  = '0;
              end
            end
            PB_CPL:  state_d = remain ? S_ONE : S_RX1;
            PB_WAIT: state_d = S_PROC;
            PB_STAT: state_d = S_SW2;
            default: begin
              state_d = S_IDLE; done_d = 1'b1; err_d = 1'b1; cause_d = C_PROTO;
            end
          endcase
        end
      end
      S_BURST: begin
        if (tx_fire) begin
          ptr_d = ptr_q + LEN_W'(1);
          if (at_cmd_end) state_d = S_PROC;
        end
      end
      S_ONE: begin
        if (tx_fire) begin
          ptr_d   = ptr_q + LEN_W'(1);
          state_d = S_PROC;
        end
      end
      S_RXN: begin
        if (rx_err || rx_tmo) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = 1'b1;
          cause_d = rx_err ? C_RXE : C_TMO;
        end else if (rx_valid) begin
          xcnt_d = xcnt_q + RSP_W'(1);
          if (xcnt_q == rxn_final) begin
            state_d = S_IDLE; done_d = 1'b1;
          end
        end
      end
      S_RX1: begin
        if (rx_err) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = 1'b1; cause_d = C_RXE;
        end else if (rx_tmo) begin
          state_d = S_IDLE; done_d = 1'b1;
        end else if (rx_valid) begin
          state_d = S_PROC;
        end
      end
      S_SW2: begin
        if (rx_err || rx_tmo) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = 1'b1;
          cause_d = rx_err ? C_RXE : C_TMO;
        end else if (rx_valid) begin
          state_d = S_IDLE; done_d = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      xcnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cause_q <= C_NONE;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      xcnt_q  <= xcnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      cause_q <= cause_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign err_cause = cause_q;

  // R10: last flag only accompanies an offered byte
  a_r10_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R3: a stalled byte stays offered at the same index
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(cmd_idx)));

  // R1: nothing is written to the response buffer during the header
  a_r1_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HDR) |-> !rsp_we);

  // R12: completion is a single-cycle pulse
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: an error outcome always carries a cause, a clean one never does
  a_r12_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_cause != 2'd0)));

  // R5: a single-byte transfer returns to procedure wait
  a_r5_one_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_ONE) && tx_ready) |=> (state_q == S_PROC));

endmodule

// File: tb/sim_t0_cmd_engine.sv
module sim_t0_cmd_engine;

  localparam int unsigned CMD_DEPTH = 16;
  localparam int unsigned RSP_W     = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [4:0]  cmd_len;
  logic [3:0]  cmd_idx;
  logic [7:0]  cmd_data;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_byte;
  logic        rx_valid, rx_err, rx_tmo;
  logic [7:0]  rx_byte;
  logic        rsp_we;
  logic [8:0]  rsp_idx, rsp_count;
  logic [7:0]  rsp_byte;
  logic        busy, done, err;
  logic [1:0]  err_cause;

  logic [7:0]  cmd_mem [0:15];
  logic [7:0]  tx_log  [0:31];
  logic        tx_llog [0:31];
  logic [7:0]  rsp_log [0:31];
  int          tx_n, rsp_n;
  int          checks, errors;
  logic        stall_en;

  always #10 clk = ~clk;

  assign cmd_data = cmd_mem[cmd_idx];

  t0_cmd_engine #(.CMD_DEPTH(CMD_DEPTH), .RSP_W(RSP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err), .rx_tmo(rx_tmo),
    .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte), .rsp_count(rsp_count),
    .busy(busy), .done(done), .err(err), .err_cause(err_cause)
  );

  // transmitter readiness model
  always @(posedge clk) begin
    #2;
    if (stall_en) tx_ready = ~tx_ready;
    else          tx_ready = 1'b1;
  end

  // record transfers that commit at the coming edge
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && tx_n < 32) begin
      tx_log[tx_n]  = tx_byte;
      tx_llog[tx_n] = tx_last;
      tx_n++;
    end
    if (rst_n && rsp_we) begin
      rsp_log[rsp_idx[4:0]] = rsp_byte;
      rsp_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic rx_pulse(input logic [7:0] b, input logic e, input logic t);
    rx_byte = b; rx_valid = !e && !t; rx_err = e; rx_tmo = t;
    tick();
    rx_valid = 1'b0; rx_err = 1'b0; rx_tmo = 1'b0;
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 200 && tx_n < n; i++) tick();
    chk(tx_n >= n, "wait_tx R1", tx_n, n);
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, tag, 0, 1);
  endtask

  task automatic load5(input logic [7:0] b0, b1, b2, b3, b4);
    cmd_mem[0] = b0; cmd_mem[1] = b1; cmd_mem[2] = b2;
    cmd_mem[3] = b3; cmd_mem[4] = b4;
  endtask

  task automatic begin_cmd(input int len);
    tx_n = 0; rsp_n = 0;
    cmd_len = 5'(len);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic finish_check(input string tag, input logic e, input int c, input int cnt);
    chk(err == e, {tag, " err"}, err, e);
    chk(err_cause == 2'(c), {tag, " cause"}, err_cause, c);
    chk(rsp_count == 9'(cnt), {tag, " count"}, rsp_count, cnt);
    @(negedge clk);
    chk(!done, "R12 done single cycle", done, 0);
    tick();
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !tx_valid, "R12 reset outputs", {busy, done, err, tx_valid}, 0);
    chk(rsp_count == 0, "R12 reset count", rsp_count, 0);
  endtask

  task automatic t_ack_burst();
    load5(8'hA0, 8'hD6, 8'h00, 8'h00, 8'h03);
    cmd_mem[5] = 8'h11; cmd_mem[6] = 8'h22; cmd_mem[7] = 8'h33;
    begin_cmd(8);
    wait_tx(5);
    chk(tx_log[0] == 8'hA0 && tx_log[4] == 8'h03, "R1 header order", tx_log[4], 8'h03);
    chk(tx_llog[4] && !tx_llog[3], "R10 header last flag", {tx_llog[3], tx_llog[4]}, 1);
    rx_pulse(8'hD6, 0, 0);
    wait_tx(8);
    chk(tx_log[5] == 8'h11 && tx_log[6] == 8'h22 && tx_log[7] == 8'h33, "R3 burst bytes", tx_log[7], 8'h33);
    chk(tx_llog[7] && !tx_llog[5] && !tx_llog[6], "R10 burst last flag", {tx_llog[5], tx_llog[6], tx_llog[7]}, 1);
    rx_pulse(8'h90, 0, 0);
    rx_pulse(8'h00, 0, 0);
    wait_done("R9 done after status");
    chk(rsp_log[0] == 8'h90 && rsp_log[1] == 8'h00, "R9 status bytes", rsp_log[0], 8'h90);
    chk(tx_n == 8, "R3 no extra tx", tx_n, 8);
    finish_check("R9", 0, 0, 2);
  endtask

  task automatic t_ack_read();
    load5(8'h00, 8'hB0, 8'h00, 8'h00, 8'h02);
    begin_cmd(5);
    wait_tx(5);
    rx_pulse(8'hB1, 0, 0);
    for (int k = 1; k <= 3; k++) rx_pulse(8'(k), 0, 0);
    @(negedge clk);
    chk(!done && busy, "R4 not done before P3+2", done, 0);
    tick();
    rx_pulse(8'h04, 0, 0);
    wait_done("R4 done after P3+2");
    chk(rsp_log[0] == 8'h01 && rsp_log[3] == 8'h04, "R2 ack bit0 ignored, data", rsp_log[3], 8'h04);
    finish_check("R4", 0, 0, 4);
  endtask

  task automatic t_single();
    load5(8'h80, 8'hD6, 8'h00, 8'h00, 8'h02);
    cmd_mem[5] = 8'h5A; cmd_mem[6] = 8'hA5;
    begin_cmd(7);
    wait_tx(5);
    rx_pulse(8'h29, 0, 0);
    wait_tx(6);
    chk(tx_log[5] == 8'h5A && tx_llog[5], "R5 single byte with last", tx_log[5], 8'h5A);
    tick(); tick();
    chk(tx_n == 6, "R5 exactly one byte", tx_n, 6);
    rx_pulse(8'h60, 0, 0);
    tick(); tick();
    chk(tx_n == 6 && rsp_count == 0 && busy, "R7 null byte inert", tx_n, 6);
    rx_pulse(8'h29, 0, 0);
    wait_tx(7);
    chk(tx_log[6] == 8'hA5 && tx_llog[6], "R5 second single byte", tx_log[6], 8'hA5);
    rx_pulse(8'h28, 0, 0);
    rx_pulse(8'hAA, 0, 0);
    chk(rsp_count == 1 && busy, "R6 one byte received", rsp_count, 1);
    rx_pulse(8'h61, 0, 0);
    rx_pulse(8'h10, 0, 0);
    wait_done("R9 done after 6X status");
    chk(rsp_log[0] == 8'hAA && rsp_log[1] == 8'h61 && rsp_log[2] == 8'h10, "R9 6X status capture", rsp_log[1], 8'h61);
    finish_check("R6", 0, 0, 3);
  endtask

  task automatic t_rx1_end(input logic use_err);
    load5(8'h00, 8'hC0, 8'h00, 8'h00, 8'h00);
    begin_cmd(5);
    wait_tx(5);
    rx_pulse(8'h3F, 0, 0);
    if (use_err) begin
      rx_pulse(8'h77, 0, 0);
      rx_pulse(8'h3F, 0, 0);
      rx_pulse(8'h00, 1, 0);
      wait_done("R6 error abort");
      finish_check("R6 rx error", 1, 2, 1);
    end else begin
      rx_pulse(8'h00, 0, 1);
      wait_done("R6 timeout end");
      finish_check("R6 timeout clean", 0, 0, 0);
    end
  endtask

  task automatic t_proc_fail(input int mode);
    load5(8'h00, 8'hC0, 8'h00, 8'h00, 8'h00);
    begin_cmd(5);
    wait_tx(5);
    if (mode == 0) begin
      rx_pulse(8'h00, 1, 0);
      wait_done("R8 rx error");
      finish_check("R8 rx error", 1, 2, 0);
    end else if (mode == 1) begin
      rx_pulse(8'h00, 0, 1);
      wait_done("R8 timeout");
      finish_check("R8 timeout", 1, 1, 0);
    end else begin
      rx_pulse(8'h12, 0, 0);
      wait_done("R11 bad byte");
      finish_check("R11 protocol", 1, 3, 0);
    end
  endtask

  task automatic t_hdr_ignore();
    load5(8'h00, 8'hA4, 8'h00, 8'h00, 8'h00);
    stall_en = 1'b1;
    begin_cmd(5);
    tick();
    chk(tx_n < 5, "R1 pulse lands in header", tx_n, 4);
    rx_pulse(8'h90, 0, 0);
    wait_tx(5);
    stall_en = 1'b0;
    tick();
    chk(rsp_count == 0 && busy, "R1 header rx ignored", rsp_count, 0);
    chk(tx_llog[4] && !tx_llog[2], "R10 last under stall", tx_llog[4], 1);
    rx_pulse(8'h6A, 0, 0);
    rx_pulse(8'h82, 0, 0);
    wait_done("R1 done");
    chk(rsp_log[0] == 8'h6A && rsp_log[1] == 8'h82, "R1 status after header", rsp_log[0], 8'h6A);
    finish_check("R1", 0, 0, 2);
  endtask

  task automatic t_rxn_tmo();
    load5(8'h00, 8'hB0, 8'h00, 8'h00, 8'h04);
    begin_cmd(5);
    wait_tx(5);
    rx_pulse(8'hB0, 0, 0);
    rx_pulse(8'h41, 0, 0);
    rx_pulse(8'h42, 0, 0);
    rx_pulse(8'h00, 0, 1);
    wait_done("R4 timeout abort");
    finish_check("R4 timeout", 1, 1, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R12: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; tx_n = 0; rsp_n = 0;
    stall_en = 1'b0; tx_ready = 1'b1;
    start = 1'b0; cmd_len = 5'd5;
    rx_valid = 1'b0; rx_err = 1'b0; rx_tmo = 1'b0; rx_byte = 8'h00;
    for (int i = 0; i < 16; i++) cmd_mem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    @(negedge clk);
    t_reset();
    tick();
    t_ack_burst();
    t_ack_read();
    t_single();
    t_rx1_end(1'b0);
    t_rx1_end(1'b1);
    t_proc_fail(0);
    t_proc_fail(1);
    t_proc_fail(2);
    t_hdr_ignore();
    t_rxn_tmo();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule